// File: doc/BRIEF.md
# Shared-Memory Doorbell Register Block

This block is the small register window of an inter-VM shared-memory device. Software reaches it through a 32-bit register port over a 256-byte window. The window holds an interrupt enable word, a status word that clears when it is read, a read-only word that reports the instance's own peer number, and a write-only doorbell word.

The peer number comes in on a configuration input. A doorbell write pulses a one-cycle strobe toward the transport that delivers it to another peer. The strobe carries the destination peer and a vector number. A level interrupt is raised while any enabled status bit is set. The shared-memory data path, configuration space, vector tables and the transport itself are outside the block.

Top module: `shmem_doorbell_regs`

## Requirements
- R1: While reset is applied and after it is released, irq, bell_valid, bell_peer, bell_vector, rd_valid and rd_data are zero, and the enable and status words read back as zero.
- R2: The enable word at byte offset 0x00 is fully read/write; writing 0xFFFFFFFF reads back as 0xFFFFFFFF.
- R3: A write to the status word at offset 0x04 loads it. A read returns its value and leaves it zero, so a second read returns 0.
- R4: The position word at offset 0x08 reads the peer_id input, zero-extended. Writes to it are ignored.
- R5: A read of the doorbell offset 0x0C returns zero and changes no state. Reads of any other offset than 0x00, 0x04, 0x08 return zero, and writes to unmapped offsets change nothing.
- R6: irq is high exactly when (enable AND status) is non-zero, reflecting a write on the cycle after it.
- R7: A write to offset 0x0C drives bell_valid high for one cycle on the cycle after the write. bell_peer carries write bits 31:16 and bell_vector carries the low vector bits. Both are zero whenever bell_valid is low.
- R8: A doorbell write whose bits 15:0 hold a value at or above NUM_VECTORS (default 2) produces no strobe.
- R9: rd_valid and rd_data appear on the cycle after bus_rd. If bus_rd and bus_wr are high together, the write is done and the read is dropped (no rd_valid).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| peer_id | input | PEER_W (16) | This instance's peer number |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after bus_rd |
| rd_data | output | 32 | Read data, zero when rd_valid is low |
| irq | output | 1 | Level interrupt |
| bell_valid | output | 1 | One-cycle doorbell strobe |
| bell_peer | output | PEER_W (16) | Destination peer of the doorbell |
| bell_vector | output | VEC_W (1) | Vector of the doorbell |

## Verification
A corrupted enable or status word reaches irq one cycle after the corrupting event. It also reaches rd_data on the next read, so a bench that compares every cycle sees it within a cycle. A clear-on-read that misses or hits the wrong offset leaves a stale status value. That shows on the following status read and as irq staying high. Faults in doorbell decoding or in the vector limit appear on the strobe in the cycle after the write.

// File: rtl/shmdb_pkg.sv
package shmdb_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_POSN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_BELL   = 8'h0C;

  typedef struct packed {
    logic enable;
    logic status;
    logic posn;
    logic bell;
  } reg_sel_t;
endpackage

// File: rtl/shmdb_decode.sv
module shmdb_decode
  import shmdb_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel        = '0;
    sel.enable = (addr == OFS_ENABLE);
    sel.status = (addr == OFS_STATUS);
    sel.posn   = (addr == OFS_POSN);
    sel.bell   = (addr == OFS_BELL);
  end
endmodule

// File: rtl/shmdb_irq_regs.sv
module shmdb_irq_regs
  import shmdb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_enable,
  input  logic              wr_status,
  input  logic              rd_status,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] enable_q,
  output logic [DATA_W-1:0] status_q,
  output logic              irq
);
  logic [DATA_W-1:0] enable_d, status_d;
  logic              enable_ce, status_ce;

  always_comb begin
    enable_ce = wr_enable;
    enable_d  = wdata;
    status_ce = wr_status | rd_status;
    status_d  = wr_status ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      status_q <= '0;
    end else begin
      if (enable_ce) enable_q <= enable_d;
      if (status_ce) status_q <= status_d;
    end
  end

  assign irq = |(enable_q & status_q);
endmodule

// File: rtl/shmdb_doorbell.sv
module shmdb_doorbell
  import shmdb_pkg::*;
#(
  parameter int PEER_W      = 16,
  parameter int NUM_VECTORS = 2,
  parameter int VEC_W       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_bell,
  input  logic [DATA_W-1:0] wdata,
  output logic              bell_valid,
  output logic [PEER_W-1:0] bell_peer,
  output logic [VEC_W-1:0]  bell_vector
);
  logic [15:0]       vec_field;
  logic              vec_ok;
  logic              valid_d;
  logic [PEER_W-1:0] peer_d;
  logic [VEC_W-1:0]  vec_d;

  always_comb begin
    vec_field = wdata[15:0];
    vec_ok    = ({16'd0, vec_field} < 32'(NUM_VECTORS));
    valid_d   = wr_bell & vec_ok;
    peer_d    = valid_d ? wdata[16 +: PEER_W] : '0;
    vec_d     = valid_d ? vec_field[VEC_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bell_valid  <= 1'b0;
      bell_peer   <= '0;
      bell_vector <= '0;
    end else begin
      bell_valid  <= valid_d;
      bell_peer   <= peer_d;
      bell_vector <= vec_d;
    end
  end
endmodule

// File: rtl/shmem_doorbell_regs.sv
module shmem_doorbell_regs
  import shmdb_pkg::*;
#(
  parameter int PEER_W      = 16,
  parameter int NUM_VECTORS = 2,
  localparam int VEC_W      = (NUM_VECTORS > 1) ? $clog2(NUM_VECTORS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PEER_W-1:0] peer_id,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              bell_valid,
  output logic [PEER_W-1:0] bell_peer,
  output logic [VEC_W-1:0]  bell_vector
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  reg_sel_t          sel;
  logic              rd_en;
  logic [DATA_W-1:0] enable_q, status_q;
  logic [DATA_W-1:0] rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  shmdb_decode u_dec (.addr(bus_addr), .sel(sel));

  assign rd_en = bus_rd & ~bus_wr;

  shmdb_irq_regs u_irq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_enable (bus_wr & sel.enable),
    .wr_status (bus_wr & sel.status),
    .rd_status (rd_en & sel.status),
    .wdata     (bus_wdata),
    .enable_q  (enable_q),
    .status_q  (status_q),
    .irq       (irq)
  );

  shmdb_doorbell #(
    .PEER_W      (PEER_W),
    .NUM_VECTORS (NUM_VECTORS),
    .VEC_W       (VEC_W)
  ) u_bell (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_bell     (bus_wr & sel.bell),
    .wdata       (bus_wdata),
    .bell_valid  (bell_valid),
    .bell_peer   (bell_peer),
    .bell_vector (bell_vector)
  );

  always_comb begin
    rdata_d = '0;
    if (rd_en) begin
      unique case (1'b1)
        sel.enable: rdata_d = enable_q;
        sel.status: rdata_d = status_q;
        sel.posn:   rdata_d = {{(DATA_W-PEER_W){1'b0}}, peer_id};
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rdata_d;
    end
  end
endmodule

// File: rtl/shmdb_chk.sv
module shmdb_chk
  import shmdb_pkg::*;
#(
  parameter int PEER_W      = 16,
  parameter int NUM_VECTORS = 2,
  parameter int VEC_W       = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PEER_W-1:0] peer_id,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic              bell_valid,
  input logic [PEER_W-1:0] bell_peer,
  input logic [VEC_W-1:0]  bell_vector
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!irq && !bell_valid && !rd_valid && rd_data == '0));

  // R9
  read_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_rd && !bus_wr));

  // R3
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == OFS_STATUS) |=> !irq);

  // R6
  enable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_ENABLE && bus_wdata == '0) |=> !irq);

  // R4
  posn_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(bus_addr) == OFS_POSN) |-> rd_data == {{(DATA_W-PEER_W){1'b0}}, $past(peer_id)});

  // R7
  bell_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bell_valid |-> $past(bus_wr && bus_addr == OFS_BELL));

  // R8
  bell_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bell_valid |-> (32'(bell_vector) < 32'(NUM_VECTORS)));

  // R7
  bell_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bell_valid |-> (bell_peer == '0 && bell_vector == '0));
endmodule

bind shmem_doorbell_regs shmdb_chk #(
  .PEER_W      (PEER_W),
  .NUM_VECTORS (NUM_VECTORS),
  .VEC_W       (VEC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .peer_id     (peer_id),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .irq         (irq),
  .bell_valid  (bell_valid),
  .bell_peer   (bell_peer),
  .bell_vector (bell_vector)
);

// File: tb/sim_shmem_doorbell_regs.sv
`timescale 1ns/1ps
module sim_shmem_doorbell_regs;
  localparam int NV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] peer_id = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid, irq, bell_valid;
  logic [31:0] rd_data;
  logic [15:0] bell_peer;
  logic [0:0]  bell_vector;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shmem_doorbell_regs #(.PEER_W(16), .NUM_VECTORS(NV)) u0 (
    .clk, .rst_n, .peer_id, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
    .rd_valid, .rd_data, .irq, .bell_valid, .bell_peer, .bell_vector);

  // behavioural reference
  logic [31:0] m_en, m_st, e_rdata;
  bit e_rv, e_bv;
  int e_peer, e_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_st = 0; e_rv = 0; e_rdata = 0; e_bv = 0; e_peer = 0; e_vec = 0;
    end else begin
      e_rv = bus_rd && !bus_wr;
      e_rdata = 0;
      if (e_rv) begin
        if (bus_addr == 8'h00) e_rdata = m_en;
        else if (bus_addr == 8'h04) begin e_rdata = m_st; m_st = 0; end
        else if (bus_addr == 8'h08) e_rdata = {16'd0, peer_id};
      end
      e_bv = 0; e_peer = 0; e_vec = 0;
      if (bus_wr) begin
        if (bus_addr == 8'h00) m_en = bus_wdata;
        if (bus_addr == 8'h04) m_st = bus_wdata;
        if (bus_addr == 8'h0C && int'(bus_wdata[15:0]) < NV) begin
          e_bv = 1; e_peer = int'(bus_wdata[31:16]); e_vec = int'(bus_wdata[15:0]);
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    chk("R9 rd_valid", 32'(rd_valid), 32'(e_rv));
    chk("R9 rd_data", rd_data, e_rdata);
    chk("R6 irq", 32'(irq), 32'(|(m_en & m_st)));
    chk("R7 bell_valid", 32'(bell_valid), 32'(e_bv));
    chk("R7 bell_peer", 32'(bell_peer), 32'(e_peer));
    chk("R7 bell_vector", 32'(bell_vector), 32'(e_vec));
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk); bus_rd = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); #1;
    chk(req, rd_data, exp);
    @(negedge clk); bus_rd = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 during reset
    chk("R1 irq", 32'(irq), 0);
    chk("R1 bell_valid", 32'(bell_valid), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    rd(8'h00, 0, "R1 enable");
    rd(8'h04, 0, "R1 status");
    rd(8'h08, 0, "R4 posn zero");
    // R2
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'hFFFF_FFFF, "R2 enable");
    // R6 / R3
    wr(8'h04, 32'h1);
    chk("R6 irq set", 32'(irq), 1);
    rd(8'h04, 32'h1, "R3 first read");
    chk("R3 irq after clear", 32'(irq), 0);
    rd(8'h04, 32'h0, "R3 second read");
    // R4
    wr(8'h08, 32'h1);
    rd(8'h08, 32'h0, "R4 write ignored");
    peer_id = 16'h0005;
    rd(8'h08, 32'h5, "R4 peer");
    // R5
    wr(8'h04, 32'h3);
    rd(8'h0C, 32'h0, "R5 bell read");
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, 32'h0, "R5 unmapped");
    rd(8'h00, 32'hFFFF_FFFF, "R5 enable kept");
    rd(8'h04, 32'h3, "R5 status kept");
    // R6 masking
    wr(8'h04, 32'h4);
    wr(8'h00, 32'h0);
    chk("R6 masked", 32'(irq), 0);
    // R7
    @(negedge clk); bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'h0007_0001;
    @(posedge clk); #1;
    chk("R7 strobe", 32'(bell_valid), 1);
    chk("R7 peer", 32'(bell_peer), 7);
    chk("R7 vector", 32'(bell_vector), 1);
    @(negedge clk); bus_wr = 0;
    @(posedge clk); #1;
    chk("R7 one cycle", 32'(bell_valid), 0);
    // R8
    @(negedge clk); bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'h0003_0002;
    @(posedge clk); #1;
    chk("R8 dropped", 32'(bell_valid), 0);
    @(negedge clk); bus_wr = 0;
    // R9 collision
    @(negedge clk); bus_wr = 1; bus_rd = 1; bus_addr = 8'h00; bus_wdata = 32'hA5A5_0000;
    @(posedge clk); #1;
    chk("R9 read dropped", 32'(rd_valid), 0);
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    rd(8'h00, 32'hA5A5_0000, "R9 write done");
    // random traffic, compared every cycle
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      bus_wr = ($urandom % 3) == 0;
      bus_rd = ($urandom % 2) == 0;
      case ($urandom % 6)
        0: bus_addr = 8'h00;
        1: bus_addr = 8'h04;
        2: bus_addr = 8'h08;
        3: bus_addr = 8'h0C;
        4: bus_addr = 8'h06;
        default: bus_addr = 8'hFC;
      endcase
      bus_wdata = {16'($urandom), 16'($urandom % 4)};
      if (($urandom % 50) == 0) peer_id = 16'($urandom);
    end
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule